// File: doc/BRIEF.md
# Paced Sensor SPI Host

This block is the host side of a serial link to a register-mapped sensor. Each transaction is one 16-bit frame. SCLK idles high. The host changes MOSI on falling SCLK edges and captures MISO on rising SCLK edges. The caller presents a write/read flag, a 6-bit register address and an 8-bit value with a one-cycle start strobe. The block then runs the frame and returns the 16 bits it received, together with a one-cycle done pulse.

The sensor allows different link speeds depending on its sample-time setting, and the host takes that setting as an 8-bit code input. A low code selects the fast setting, with a higher SCLK rate and a shorter minimum spacing between frames. A high code selects the normal setting, with a slower SCLK and a longer spacing. The host samples the code when it accepts a request. From that code it takes the SCLK half period and the minimum time from one chip-select falling edge to the next. If a new request arrives too early, the host holds chip select high until that spacing has passed, so the caller never has to count the stall itself.

All timing limits are given as frequencies and nanoseconds and are turned into system-clock counts at elaboration. Each count is rounded up, so no limit is ever undercut.

Top module: `sensor_spi_host`

## Requirements
- R1: After reset, spi_cs_n and spi_sclk are 1 and busy and done are 0.
- R2: A frame has exactly 16 rising SCLK edges with chip select low, and SCLK is high whenever chip select is high. The bits on MOSI at those rising edges are, in order: wr (1 = write), addr[5] down to addr[0], then wdata[7] down to wdata[0].
- R3: rdata holds the 16 MISO bits captured on the 16 rising edges, the first one in bit 15. The first bit is the one the sensor presents as soon as chip select falls.
- R4: When smpl_code is 7 or below (fast setting), every SCLK low and high phase lasts ceil(CLK_HZ / (2·FAST_SCLK_HZ)) clocks.
- R5: When smpl_code is 8 or above (normal setting), every SCLK low and high phase lasts ceil(CLK_HZ / (2·NORM_SCLK_HZ)) clocks.
- R6: The first SCLK falling edge comes exactly ceil(CS_SETUP_NS·CLK_HZ/1e9) clocks after chip select falls.
- R7: Chip select rises one SCLK half period after the last rising SCLK edge.
- R8: The distance in clocks between consecutive chip-select falling edges is at least ceil(PERIOD_NS·CLK_HZ/1e9), where PERIOD_NS is the fast or normal period chosen by the new frame's code. Chip select falls at the earliest clock allowed by both that bound and the accepted start, which is one clock after acceptance.
- R9: done is high for exactly one clock, the clock after chip select rises. In that clock busy is 0 and rdata is valid.
- R10: A start strobe while busy is 1 is ignored. No extra frame follows, and the running frame's MOSI bits and timing are unchanged.
- R11: smpl_code is sampled only when a start is accepted. Changes to it during a frame do not alter that frame's SCLK timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| wr | input | 1 | 1 = write, 0 = read; sent first |
| addr | input | 6 | Register address, sent MSB first |
| wdata | input | 8 | Data byte, sent MSB first after the address |
| smpl_code | input | 8 | Sensor sample-time code; 7 or below selects the fast setting |
| busy | output | 1 | High from the clock after acceptance until done |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Word received in the last frame |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
Frames are run with the codes 7 and 8 on either side of the mode boundary, with codes 0 and 0xFF at the extremes, and with random codes. A wrong threshold shows up as a wrong SCLK half period. Requests are issued both back-to-back and after random idle gaps, including fast-after-normal and normal-after-fast pairs. This separates a period enforced from the previous chip-select edge from one taken from the wrong mode or from the start strobe. Response words with opposite end bits (0x8001, 0x7FFE) and random words show a lost first MISO bit or a shifted capture. Random frames also pulse start and change the code mid-frame, which exposes a host that accepts a second request or re-reads the code.

// File: rtl/sensor_spi_pkg.sv
// Shared types and elaboration-time helpers for the sensor SPI host.
// Assumes every count fits in 32 bits after rounding.
package sensor_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } host_state_t;

    // Rounded-up integer division used to turn limits into clock counts.
    function automatic int unsigned cycles_ceil(longint unsigned num, longint unsigned den);
        longint unsigned q;
        q = (num + den - 64'd1) / den;
        return q[31:0];
    endfunction

endpackage

// File: rtl/sensor_spi_pace.sv
// Frame pacing: counts clocks since the last chip-select falling edge and
// reports when the next frame may start for the selected mode.
// Assumes FAST_CYC and NORM_CYC are both at least 1.
module sensor_spi_pace #(
    parameter int unsigned FAST_CYC = 5000,
    parameter int unsigned NORM_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall,
    input  logic fast,
    output logic ok
);
    localparam int unsigned MAX_CYC = (FAST_CYC > NORM_CYC) ? FAST_CYC : NORM_CYC;
    localparam int W = $clog2(MAX_CYC + 1);
    localparam logic [W-1:0] SAT   = W'(MAX_CYC);
    localparam logic [W-1:0] F_LIM = W'(FAST_CYC - 1);
    localparam logic [W-1:0] N_LIM = W'(NORM_CYC - 1);

    logic [W-1:0] since;

    // Saturating clock count since the last chip-select fall; starts saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since <= SAT;
        else if (cs_fall)
            since <= '0;
        else if (since != SAT)
            since <= since + 1'b1;
    end

    assign ok = since >= (fast ? F_LIM : N_LIM);

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_fall && since != SAT) |=> (since == $past(since) + 1'b1));

    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_fall && since == SAT) |=> (since == SAT));

endmodule

// File: rtl/sensor_spi_shift.sv
// Frame shifter: loads the outgoing word, puts one bit on MOSI per drive
// strobe and captures MISO per sample strobe, counting captured bits.
// Assumes the strobes are never active together.
module sensor_spi_shift #(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  drive,
    input  logic                  sample,
    input  logic                  miso,
    output logic                  mosi,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  all_in
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);

    logic [FRAME_BITS-1:0] tx;
    logic [CW-1:0]         nbit;

    // Shift out on drive, shift in on sample, restart on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx      <= '0;
            rx_word <= '0;
            nbit    <= '0;
            mosi    <= 1'b1;
        end else if (load) begin
            tx   <= tx_word;
            nbit <= '0;
        end else begin
            if (drive) begin
                mosi <= tx[FRAME_BITS-1];
                tx   <= {tx[FRAME_BITS-2:0], 1'b0};
            end
            if (sample) begin
                rx_word <= {rx_word[FRAME_BITS-2:0], miso};
                nbit    <= nbit + 1'b1;
            end
        end
    end

    assign all_in = (nbit == FULL);

    p_bit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nbit <= FULL);

    p_no_extra_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        all_in |-> !sample);

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive && sample));

endmodule

// File: rtl/sensor_spi_host.sv
// Sensor SPI host: one 16-bit frame per accepted request, with SCLK idling high,
// MOSI changed on falling edges and MISO captured on rising edges. The SCLK
// half period and the minimum chip-select period come from the latched mode.
// Assumes CS_SETUP_NS > 0 and that a frame is shorter than either period.
module sensor_spi_host
    import sensor_spi_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 125_000_000,
    parameter int unsigned FAST_SCLK_HZ   = 2_500_000,
    parameter int unsigned NORM_SCLK_HZ   = 1_000_000,
    parameter int unsigned FAST_PERIOD_NS = 40_000,
    parameter int unsigned NORM_PERIOD_NS = 100_000,
    parameter int unsigned CS_SETUP_NS    = 49,
    parameter logic [7:0]  FAST_MAX_CODE  = 8'h07
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wr,
    input  logic [5:0]  addr,
    input  logic [7:0]  wdata,
    input  logic [7:0]  smpl_code,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int unsigned FRAME_BITS = 16;
    localparam int unsigned HALF_F = cycles_ceil(64'(CLK_HZ), 64'(2) * FAST_SCLK_HZ);
    localparam int unsigned HALF_N = cycles_ceil(64'(CLK_HZ), 64'(2) * NORM_SCLK_HZ);
    localparam int unsigned SETUP  = cycles_ceil(64'(CS_SETUP_NS) * CLK_HZ, 64'd1_000_000_000);
    localparam int unsigned PER_F  = cycles_ceil(64'(FAST_PERIOD_NS) * CLK_HZ, 64'd1_000_000_000);
    localparam int unsigned PER_N  = cycles_ceil(64'(NORM_PERIOD_NS) * CLK_HZ, 64'd1_000_000_000);
    localparam int unsigned HALF_MAX = (HALF_F > HALF_N) ? HALF_F : HALF_N;
    localparam int unsigned CNT_MAX  = (HALF_MAX > SETUP) ? HALF_MAX : SETUP;
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP - 1);
    localparam logic [CW-1:0] HF_LAST    = CW'(HALF_F - 1);
    localparam logic [CW-1:0] HN_LAST    = CW'(HALF_N - 1);

    host_state_t     state;
    logic [CW-1:0]   cnt;
    logic            fast_q;
    logic [CW-1:0]   half_last;
    logic            load, drive, sample, all_in, pace_ok, cs_fall;
    logic [15:0]     rx_word;

    assign busy      = (state != ST_IDLE);
    assign half_last = fast_q ? HF_LAST : HN_LAST;
    assign load      = (state == ST_IDLE) && start;
    assign cs_fall   = (state == ST_GAP) && pace_ok;
    assign sample    = (state == ST_LOW) && (cnt == half_last);
    assign drive     = ((state == ST_SETUP) && (cnt == SETUP_LAST)) ||
                       ((state == ST_HIGH) && (cnt == half_last) && !all_in);

    sensor_spi_pace #(
        .FAST_CYC (PER_F),
        .NORM_CYC (PER_N)
    ) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_fall (cs_fall),
        .fast    (fast_q),
        .ok      (pace_ok)
    );

    sensor_spi_shift #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .tx_word ({wr, addr, wdata}),
        .drive   (drive),
        .sample  (sample),
        .miso    (spi_miso),
        .mosi    (spi_mosi),
        .rx_word (rx_word),
        .all_in  (all_in)
    );

    // Frame sequencer: pacing wait, chip-select setup, SCLK phases, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            fast_q   <= 1'b0;
            spi_cs_n <= 1'b1;
            spi_sclk <= 1'b1;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        fast_q <= (smpl_code <= FAST_MAX_CODE);
                        state  <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (pace_ok) begin
                        spi_cs_n <= 1'b0;
                        cnt      <= '0;
                        state    <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt == SETUP_LAST) begin
                        spi_sclk <= 1'b0;
                        cnt      <= '0;
                        state    <= ST_LOW;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LOW: begin
                    if (cnt == half_last) begin
                        spi_sclk <= 1'b1;
                        cnt      <= '0;
                        state    <= ST_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt == half_last) begin
                        cnt <= '0;
                        if (all_in) begin
                            spi_cs_n <= 1'b1;
                            state    <= ST_DONE;
                        end else begin
                            spi_sclk <= 1'b0;
                            state    <= ST_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    done  <= 1'b1;
                    rdata <= rx_word;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sclk);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && $past(spi_cs_n) && !busy));

    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fast_q));

    p_cs_quiet_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && !pace_ok) |=> spi_cs_n);

endmodule

// File: tb/sim_sensor_spi_host.sv
// Bench: directed boundary frames plus seeded random frames. A sensor model
// drives MISO and a monitor measures edge timing in clock cycles.
module sim_sensor_spi_host;
    localparam int CLK_HZ = 125_000_000;
    localparam int F_SCLK = 2_500_000;
    localparam int N_SCLK = 1_000_000;
    localparam int FP_NS  = 8000;
    localparam int NP_NS  = 20000;
    localparam int SU_NS  = 49;

    function automatic int ceil_of(longint a, longint b, longint u);
        return int'((a * b + u - 1) / u);
    endfunction

    localparam int HF = ceil_of(CLK_HZ, 1, 2 * F_SCLK);
    localparam int HN = ceil_of(CLK_HZ, 1, 2 * N_SCLK);
    localparam int SU = ceil_of(SU_NS, CLK_HZ, 1_000_000_000);
    localparam int PF = ceil_of(FP_NS, CLK_HZ, 1_000_000_000);
    localparam int PN = ceil_of(NP_NS, CLK_HZ, 1_000_000_000);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, wr = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0, smpl_code = '0;
    logic busy, done, spi_cs_n, spi_sclk, spi_mosi;
    logic spi_miso = 1'b0;
    logic [15:0] rdata;

    sensor_spi_host #(
        .CLK_HZ(CLK_HZ), .FAST_SCLK_HZ(F_SCLK), .NORM_SCLK_HZ(N_SCLK),
        .FAST_PERIOD_NS(FP_NS), .NORM_PERIOD_NS(NP_NS), .CS_SETUP_NS(SU_NS),
        .FAST_MAX_CODE(8'h07)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr),
        .wdata(wdata), .smpl_code(smpl_code), .busy(busy), .done(done),
        .rdata(rdata), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int vectors = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sensor model: first bit at chip-select fall, later bits from the 2nd falling SCLK.
    logic [15:0] resp = '0;
    int sfalls = 0;
    always @(negedge spi_cs_n) begin
        spi_miso = resp[15];
        sfalls = 0;
    end
    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            sfalls++;
            if (sfalls >= 2 && sfalls <= 16) spi_miso = resp[16 - sfalls];
        end
    end

    // Monitor: edge times in clock cycles, MOSI bits at rising SCLK.
    int fall_cyc = 0, cs_rise_cyc = 0, last_edge = 0, last_rise = 0;
    int setup_len = 0, rel_len = 0, rises = 0, run_err = 0, frames = 0, exp_half = 0;
    bit seen_fall = 0;
    logic [15:0] mosi_word = '0;
    logic p_cs = 1'b1, p_sclk = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cs && !spi_cs_n) begin
                frames++; fall_cyc = cyc; rises = 0; run_err = 0; seen_fall = 0;
            end
            if (!spi_cs_n && p_sclk != spi_sclk) begin
                if (!seen_fall) begin
                    setup_len = cyc - fall_cyc; seen_fall = 1;
                end else if (cyc - last_edge != exp_half) begin
                    run_err++;
                end
                last_edge = cyc;
                if (spi_sclk) begin
                    rises++; last_rise = cyc;
                    mosi_word = {mosi_word[14:0], spi_mosi};
                end
            end
            if (!p_cs && spi_cs_n) begin
                cs_rise_cyc = cyc; rel_len = cyc - last_rise;
            end
        end
        p_cs = spi_cs_n;
        p_sclk = spi_sclk;
    end

    int prev_fall = -1;
    int accepted = 0;

    task automatic xfer(input logic w, input logic [5:0] a, input logic [7:0] d,
                        input logic [7:0] code, input logic [15:0] r,
                        input int delay, input bit poke);
        int per, accept_cyc, exp_fall, k, dcyc;
        bit fast;
        repeat (delay) @(negedge clk);
        fast = (code <= 8'h07);
        resp = r;
        exp_half = fast ? HF : HN;
        per = fast ? PF : PN;
        start = 1'b1; wr = w; addr = a; wdata = d; smpl_code = code;
        accept_cyc = cyc + 1;
        accepted++;
        exp_fall = accept_cyc + 1;
        if (prev_fall >= 0 && prev_fall + per > exp_fall) exp_fall = prev_fall + per;
        k = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            k++;
            if (poke && k == 40) begin
                // R10 / R11 stimulus: a second request and a code flip mid-frame
                start = 1'b1; wr = ~w; addr = ~a; wdata = ~d;
                smpl_code = fast ? 8'h20 : 8'h00;
            end
        end while (!done);
        dcyc = cyc;
        chk(dcyc == cs_rise_cyc + 1, "R9 done one clock after cs rise", dcyc, cs_rise_cyc + 1);
        chk(!busy, "R9 busy low with done", busy, 0);
        chk(rdata == r, "R3 received word", rdata, r);
        chk(mosi_word == {w, a, d}, "R2 mosi bit order", mosi_word, {w, a, d});
        chk(rises == 16, "R2 rising edge count", rises, 16);
        chk(run_err == 0, fast ? "R4 fast half period" : "R5 normal half period", run_err, 0);
        chk(setup_len == SU, "R6 cs setup", setup_len, SU);
        chk(rel_len == exp_half, "R7 cs release", rel_len, exp_half);
        chk(fall_cyc == exp_fall, "R8 cs fall spacing", fall_cyc, exp_fall);
        prev_fall = fall_cyc;
        @(negedge clk);
        chk(!done, "R9 done single pulse", done, 0);
        chk(frames == accepted && spi_cs_n, "R10 no extra frame", frames, accepted);
        if (poke) chk(1'b1, "R11 mid-frame code change covered above", 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1: outputs held in reset state
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b1, "R1 bus idle in reset", {spi_cs_n, spi_sclk}, 2'b11);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1 busy and done low after reset", {busy, done}, 0);
        chk(spi_cs_n && spi_sclk, "R1 bus idle after reset", {spi_cs_n, spi_sclk}, 2'b11);

        // Directed: code boundary, back-to-back spacing, mode switches, end-bit patterns
        xfer(1'b1, 6'h3F, 8'hFF, 8'h07, 16'h8001, 0, 1'b0);
        xfer(1'b1, 6'h2A, 8'h5A, 8'h07, 16'h7FFE, 0, 1'b0);
        xfer(1'b0, 6'h00, 8'h00, 8'h08, 16'h7FFE, 0, 1'b0);
        xfer(1'b0, 6'h15, 8'hA5, 8'h00, 16'hFFFF, 0, 1'b1);
        xfer(1'b1, 6'h01, 8'h80, 8'hFF, 16'h0000, 0, 1'b1);
        xfer(1'b0, 6'h20, 8'h01, 8'h08, 16'h8001, 0, 1'b0);

        for (int i = 0; i < 24; i++) begin
            int dl;
            dl = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 3000)) : 0;
            xfer(1'($urandom_range(0, 1)), 6'($urandom), 8'($urandom),
                 8'($urandom_range(0, 15)), 16'($urandom), dl, 1'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule